// File: doc/BRIEF.md
# Two-Wire Programming Link Target Responder

This block is the target end of a half-duplex two-wire serial link: one wire carries a clock that the external master supplies, and the other carries data in both directions. The block brings both wires into the local clock domain and detects clock edges there. It collects 16-bit command words and hands each finished word to a local processing port. Once the whole command has arrived, it takes over the data wire. It holds the wire high while local logic works on the command. When the local logic reports completion, the block pulls the wire low for a fixed number of system clocks. It then shifts the response words out, one bit per master clock.

Command length is not set in advance. The first command word carries a 4-bit count field, and the local processing logic supplies the response length. The response phase has no timeout, so the block waits for as long as the master takes to clock each bit. After the final response bit it releases the wire and goes back to receiving commands.

Top module: `pls_responder`

## Requirements
- R1: Reset releases the data wire (`sdata_oe` low), emits no `cmd_valid` or `rsp_take`, and discards any partly received command word.
- R2: In the receive state each rising serial clock edge samples one command bit, most significant bit first. Every sixteenth sample produces a one-cycle `cmd_valid` with the assembled word on `cmd_word`.
- R3: Bits [11:8] of the first word of a command give its total word count, and a value of 0 counts as 1. `cmd_last` is high together with `cmd_valid` on the final word only.
- R4: After the last command bit the block leaves the wire released until the next falling serial clock edge. From then on it drives the wire high and holds it high until `proc_done`.
- R5: From the end of a command until its response has been fully sent, serial clock edges never produce `cmd_valid`, and they leave the busy level unchanged.
- R6: The cycle in which `proc_done` is sampled is followed by exactly `READY_CYCLES` system cycles of a driven low level. The first response word is taken (`rsp_take`) in the last of those cycles.
- R7: Response words go out most significant bit first. A new bit appears only after a falling serial clock edge. The number of words sent is `rsp_len`, with 0 counting as 1, and `rsp_take` pulses once per word.
- R8: While no serial clock edge arrives during the response, the block keeps the current bit on the wire for any length of time.
- R9: On the sixteenth rising edge of the final response word the block releases the wire and returns to receiving commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock from the master (asynchronous) |
| sdata_in | input | 1 | Data wire as seen at the pin (asynchronous) |
| sdata_out | output | 1 | Value driven onto the data wire |
| sdata_oe | output | 1 | Data wire drive enable |
| cmd_valid | output | 1 | One-cycle strobe: a command word is complete |
| cmd_word | output | 16 | Received command word |
| cmd_last | output | 1 | Strobed word is the final word of the command |
| proc_done | input | 1 | Local processing finished; response available |
| rsp_len | input | 4 | Response word count, sampled with `proc_done` |
| rsp_data | input | 16 | Next response word, captured when `rsp_take` is high |
| rsp_take | output | 1 | Response word consumed this cycle |

## Verification
Commands are built with count fields of 0, 1, 15 and random values from 1 to 4. A field of 0 must yield a one-word command and a field of 15 must yield a long one, which separates a correct count decode from an off-by-one or an ignored field. Response lengths of 0, 1, 3 and random values vary in the same way, and they show whether the word counter and the per-word reload between words are correct. Some transactions clock the master during the busy phase, which shows whether command reception is really shut out. Others stall for a long time before reading, which separates a held bit from one that drifts. A reset in the middle of a word checks that stale bits do not shift into the next command.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned BIT_CNT_W = $clog2(WORD_W);
    localparam int unsigned LEN_LSB   = 8;
    localparam int unsigned LEN_W     = 4;

    typedef enum logic [2:0] {
        ST_RX    = 3'd0,
        ST_TURN  = 3'd1,
        ST_BUSY  = 3'd2,
        ST_READY = 3'd3,
        ST_TX    = 3'd4
    } link_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic level;
        logic data;
    } line_sample_t;

    // Total command words announced by the first word; zero means one.
    function automatic logic [LEN_W-1:0] first_word_len(input logic [WORD_W-1:0] w);
        logic [LEN_W-1:0] f;
        f = w[LEN_LSB +: LEN_W];
        return (f == '0) ? LEN_W'(1) : f;
    endfunction

endpackage

// File: rtl/pls_sync.sv
module pls_sync
    import pls_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_raw,
    input  logic         sdata_raw,
    output line_sample_t smp
);

    logic [STAGES-1:0] ck_pipe;
    logic [STAGES-1:0] dt_pipe;
    logic              ck_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_pipe[g] <= 1'b0;
                    dt_pipe[g] <= 1'b0;
                end else begin
                    ck_pipe[g] <= sclk_raw;
                    dt_pipe[g] <= sdata_raw;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    ck_pipe[g] <= 1'b0;
                    dt_pipe[g] <= 1'b0;
                end else begin
                    ck_pipe[g] <= ck_pipe[g-1];
                    dt_pipe[g] <= dt_pipe[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ck_prev <= 1'b0;
        else     ck_prev <= ck_pipe[STAGES-1];
    end

    always_comb begin
        smp.level = ck_pipe[STAGES-1];
        smp.data  = dt_pipe[STAGES-1];
        smp.rise  = ck_pipe[STAGES-1] & ~ck_prev;
        smp.fall  = ~ck_pipe[STAGES-1] & ck_prev;
    end

    assert_edge_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        smp.rise |=> !smp.rise);

endmodule

// File: rtl/pls_rx.sv
module pls_rx
    import pls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_q,
    output logic              done_q
);

    logic [WORD_W-1:0]    sh_q;
    logic [BIT_CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (shift_en) begin
                sh_q <= {sh_q[WORD_W-2:0], bit_in};
                if (cnt_q == BIT_CNT_W'(WORD_W-1)) begin
                    word_q <= {sh_q[WORD_W-2:0], bit_in};
                    done_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assert_word_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/pls_tx.sv
module pls_tx
    import pls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    input  logic              count,
    output logic              bit_out,
    output logic              last_bit
);

    logic [WORD_W-1:0]    sh_q;
    logic [BIT_CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_word;
            cnt_q <= '0;
        end else begin
            if (shift) sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            if (count) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_out  = sh_q[WORD_W-1];
    assign last_bit = (cnt_q == BIT_CNT_W'(WORD_W-1));

    assert_load_shift_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(load && shift));

endmodule

// File: rtl/pls_responder.sv
module pls_responder
    import pls_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned READY_CYCLES = 3000,
    parameter int unsigned RSP_LEN_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk_in,
    input  logic                 sdata_in,
    output logic                 sdata_out,
    output logic                 sdata_oe,
    output logic                 cmd_valid,
    output logic [WORD_W-1:0]    cmd_word,
    output logic                 cmd_last,
    input  logic                 proc_done,
    input  logic [RSP_LEN_W-1:0] rsp_len,
    input  logic [WORD_W-1:0]    rsp_data,
    output logic                 rsp_take
);

    localparam int unsigned RDY_W = (READY_CYCLES > 1) ? $clog2(READY_CYCLES) : 1;

    line_sample_t         smp;
    link_state_e          state_q;
    logic                 first_q;
    logic [LEN_W-1:0]     cmd_left_q;
    logic [RSP_LEN_W-1:0] rsp_left_q;
    logic [RDY_W-1:0]     rdy_cnt_q;
    logic                 reload_q;

    logic                 sclk_fall;
    logic                 rx_shift;
    logic [WORD_W-1:0]    rx_word;
    logic                 rx_done;
    logic [LEN_W-1:0]     cmd_total;
    logic                 is_last;
    logic                 tx_shift;
    logic                 tx_count;
    logic                 tx_bit;
    logic                 tx_last_bit;

    pls_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_raw  (sclk_in),
        .sdata_raw (sdata_in),
        .smp       (smp)
    );

    pls_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rx_shift),
        .bit_in   (smp.data),
        .word_q   (rx_word),
        .done_q   (rx_done)
    );

    pls_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (rsp_take),
        .load_word (rsp_data),
        .shift     (tx_shift),
        .count     (tx_count),
        .bit_out   (tx_bit),
        .last_bit  (tx_last_bit)
    );

    always_comb begin
        sclk_fall = smp.fall;
        rx_shift  = smp.rise && (state_q == ST_RX);
        cmd_total = first_word_len(rx_word);
        is_last   = first_q ? (cmd_total == LEN_W'(1)) : (cmd_left_q == LEN_W'(1));
        cmd_valid = rx_done;
        cmd_word  = rx_word;
        cmd_last  = rx_done && is_last;
        rsp_take  = ((state_q == ST_READY) && (rdy_cnt_q == '0)) ||
                    ((state_q == ST_TX) && reload_q && smp.fall);
        tx_shift  = (state_q == ST_TX) && smp.fall && !reload_q;
        tx_count  = (state_q == ST_TX) && smp.rise;
        sdata_oe  = (state_q == ST_BUSY) || (state_q == ST_READY) || (state_q == ST_TX);
        sdata_out = (state_q == ST_BUSY) || ((state_q == ST_TX) && tx_bit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RX;
            first_q    <= 1'b1;
            cmd_left_q <= '0;
            rsp_left_q <= '0;
            rdy_cnt_q  <= '0;
            reload_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RX: begin
                    if (rx_done) begin
                        if (is_last) begin
                            state_q <= ST_TURN;
                            first_q <= 1'b1;
                        end else begin
                            cmd_left_q <= first_q ? cmd_total - 1'b1 : cmd_left_q - 1'b1;
                            first_q    <= 1'b0;
                        end
                    end
                end
                ST_TURN: begin
                    if (smp.fall) state_q <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (proc_done) begin
                        state_q    <= ST_READY;
                        rdy_cnt_q  <= RDY_W'(READY_CYCLES - 1);
                        rsp_left_q <= (rsp_len == '0) ? RSP_LEN_W'(1) : rsp_len;
                    end
                end
                ST_READY: begin
                    if (rdy_cnt_q == '0) begin
                        state_q  <= ST_TX;
                        reload_q <= 1'b0;
                    end else begin
                        rdy_cnt_q <= rdy_cnt_q - 1'b1;
                    end
                end
                ST_TX: begin
                    if (rsp_take) reload_q <= 1'b0;
                    if (tx_count && tx_last_bit) begin
                        if (rsp_left_q == RSP_LEN_W'(1)) begin
                            state_q <= ST_RX;
                        end else begin
                            reload_q   <= 1'b1;
                            rsp_left_q <= rsp_left_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ST_RX;
            endcase
        end
    end

    assert_cmd_only_in_rx_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (state_q == ST_RX));

    assert_busy_until_done_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BUSY && !proc_done) |=> (state_q == ST_BUSY && sdata_oe && sdata_out));

    assert_ready_low_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_READY && state_q == ST_READY) |-> (sdata_oe && !sdata_out));

    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TX && $past(state_q) == ST_TX && !$past(sclk_fall)) |-> $stable(sdata_out));

    assert_release_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RX && $past(state_q) == ST_TX) |-> (!sdata_oe && $past(smp.rise)));

endmodule

// File: tb/test_pls_responder.sv
module test_pls_responder;
    import pls_pkg::*;

    localparam int unsigned RDY  = 40;
    localparam int unsigned HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic        sdata_out, sdata_oe;
    logic        cmd_valid, cmd_last;
    logic [15:0] cmd_word;
    logic        proc_done = 1'b0;
    logic [3:0]  rsp_len = '0;
    logic [15:0] rsp_data;
    logic        rsp_take;

    int n_vec = 0;
    int n_bad = 0;
    int txn = 0;
    int rsp_idx = 0;
    bit take_pend = 0;
    bit measure_en = 0;
    bit take_seen = 0;
    int low_cnt = 0;
    int take_cnt = 0;
    logic [15:0] cmd_q[$];
    bit          last_q[$];

    always #2.5 clk = ~clk;

    function automatic logic [15:0] rsp_fn(input int t, input int k);
        return 16'(t * 16'h1357) ^ 16'(k * 16'h2468) ^ 16'hA5C3;
    endfunction

    assign rsp_data = rsp_fn(txn, rsp_idx);

    pls_responder #(.READY_CYCLES(RDY)) i_pls_responder (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .sdata_oe(sdata_oe),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_last(cmd_last),
        .proc_done(proc_done), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .rsp_take(rsp_take)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            cmd_q.push_back(cmd_word);
            last_q.push_back(cmd_last);
        end
        if (rsp_take) begin
            take_pend = 1;
            take_cnt++;
        end
        if (measure_en && !take_seen) begin
            if (sdata_oe && !sdata_out) low_cnt++;
            if (rsp_take) take_seen = 1;
        end
    end

    always begin
        @(posedge clk);
        #1;
        if (take_pend) begin
            rsp_idx = rsp_idx + 1;
            take_pend = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            sclk_in = 1'b0;
            sdata_in = w[i];
            cyc(HALF);
            sclk_in = 1'b1;
            cyc(HALF);
        end
    endtask

    task automatic run_txn(input int field, input int rlen, input int busy_wait,
                           input int stall, input bit poke);
        int nw;
        int nr;
        logic [15:0] words[16];
        txn++;
        nw = (field == 0) ? 1 : field;
        nr = (rlen == 0) ? 1 : rlen;
        for (int i = 0; i < nw; i++) words[i] = 16'($urandom);
        words[0][11:8] = 4'(field);
        cmd_q.delete();
        last_q.delete();
        for (int i = 0; i < nw; i++) send_word(words[i]);
        check(!sdata_oe, "R4", "wire taken before falling edge", 32'(sdata_oe), 0);
        sclk_in = 1'b0;
        sdata_in = 1'($urandom);
        cyc(HALF);
        check(sdata_oe && sdata_out, "R4", "busy level", {sdata_oe, sdata_out}, 2'b11);
        check(cmd_q.size() == nw, "R3", "command word count", cmd_q.size(), nw);
        for (int i = 0; i < nw && i < cmd_q.size(); i++) begin
            check(cmd_q[i] == words[i], "R2", "command word", cmd_q[i], words[i]);
            check(last_q[i] == (i == nw - 1), "R3", "last flag", last_q[i], (i == nw - 1));
        end
        if (poke) begin
            for (int i = 0; i < 16; i++) begin
                sdata_in = 1'($urandom);
                sclk_in = 1'b1;
                cyc(HALF);
                sclk_in = 1'b0;
                cyc(HALF);
            end
            check(cmd_q.size() == nw, "R5", "words taken while busy", cmd_q.size(), nw);
            check(sdata_oe && sdata_out, "R5", "busy level after clocks", {sdata_oe, sdata_out}, 2'b11);
        end
        cyc(busy_wait);
        check(sdata_oe && sdata_out, "R4", "busy held", {sdata_oe, sdata_out}, 2'b11);
        rsp_idx = 0;
        take_cnt = 0;
        low_cnt = 0;
        take_seen = 0;
        measure_en = 1;
        proc_done = 1'b1;
        rsp_len = 4'(rlen);
        cyc(1);
        proc_done = 1'b0;
        cyc(RDY + 4);
        measure_en = 0;
        check(low_cnt == RDY, "R6", "ready pulse length", low_cnt, RDY);
        check(take_seen && take_cnt == 1, "R6", "first word taken at pulse end", take_cnt, 1);
        cyc(stall);
        check(sdata_oe && sdata_out == rsp_fn(txn, 0)[15], "R8", "first bit held",
              {sdata_oe, sdata_out}, {1'b1, rsp_fn(txn, 0)[15]});
        for (int k = 0; k < nr; k++) begin
            logic [15:0] got;
            got = '0;
            for (int b = 15; b >= 0; b--) begin
                cyc(HALF);
                got[b] = sdata_oe ? sdata_out : 1'bx;
                sclk_in = 1'b1;
                cyc(HALF);
                sclk_in = 1'b0;
            end
            check(got === rsp_fn(txn, k), "R7", "response word", got, rsp_fn(txn, k));
        end
        cyc(HALF);
        check(take_cnt == nr, "R7", "words taken", take_cnt, nr);
        check(!sdata_oe, "R9", "wire released after last bit", 32'(sdata_oe), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(4);
        check(!sdata_oe && !cmd_valid && !rsp_take, "R1", "reset outputs",
              {sdata_oe, cmd_valid, rsp_take}, 0);
        rst = 1'b0;
        cyc(4);
        check(!sdata_oe, "R1", "idle wire released", 32'(sdata_oe), 0);

        // directed corners
        run_txn(1, 1, 10, 0, 0);
        run_txn(0, 0, 5, 0, 0);
        run_txn(15, 3, 20, 0, 1);
        run_txn(2, 2, 3, 2000, 0);

        // reset in the middle of a word drops partial bits
        for (int i = 0; i < 7; i++) begin
            sclk_in = 1'b0; sdata_in = 1'b1; cyc(HALF);
            sclk_in = 1'b1; cyc(HALF);
        end
        sclk_in = 1'b0;
        rst = 1'b1;
        cyc(3);
        check(!sdata_oe, "R1", "wire released in reset", 32'(sdata_oe), 0);
        rst = 1'b0;
        cyc(4);
        run_txn(1, 2, 4, 0, 0);

        // random traffic
        for (int t = 0; t < 12; t++) begin
            run_txn(1 + int'($urandom_range(3)), int'($urandom_range(4)),
                    int'($urandom_range(30)), int'($urandom_range(50)), bit'($urandom_range(1)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule